// File: doc/BRIEF.md
# Floating-Point Normalizer Stage

This block is the normalization step of a single-precision floating-point datapath. It sits directly after an adder or multiplier that produces a raw 48-bit significand with two integer bits on top. In the same cycle it brings that significand back to the form `01.f`. It then adjusts the biased exponent to match and packs sign, exponent and fraction into a 32-bit word. The word is captured in one output register, so the stage drops into a pipeline with one cycle of latency.

Normalization works in either direction. If the top bit of the significand is set, the stage shifts the significand one place right and raises the exponent by one. If both integer bits are clear, a leading-one priority encoder finds the most significant set bit. A barrel shifter then moves that bit up to position 46, and the exponent drops by the same number of places. Several cases do not follow these paths:

- If the increment reaches the all-ones exponent, the result saturates to a signed infinity.
- If the decrement would reach zero or go below it, the result flushes to a signed zero.
- An all-zero significand also gives a signed zero.
- When the enable input is low, the fields pass through untouched.

Top module: `fp_normalizer`

## Requirements
- R1: With `in_enable` low, the result is `{in_sign, in_exp, in_mant[45:23]}` whatever the significand head.
- R2: With `in_enable` high and `in_mant[47:46]` equal to 2'b01, the result is `{in_sign, in_exp, in_mant[45:23]}`.
- R3: With `in_enable` high, `in_mant[47]` set and `in_exp` below 254, the result is `{in_sign, in_exp+1, in_mant[46:24]}`.
- R4: With `in_enable` high, `in_mant[47:46]` equal to 2'b00 and leading one at position p, the stage uses N = 46 - p. If N is below `in_exp`, the result is `{in_sign, in_exp-N, m[45:23]}`, where m is `in_mant` shifted left by N. Bits below the fraction are dropped (truncation).
- R5: With `in_enable` high, `in_mant[47]` set and `in_exp` of 254 or 255, the result is `{in_sign, 8'hFF, 23'h0}`.
- R6: In the R4 case, if N is greater than or equal to `in_exp`, the result is `{in_sign, 8'h00, 23'h0}`.
- R7: With `in_enable` high and `in_mant` all zero, the result is `{in_sign, 8'h00, 23'h0}`.
- R8: The output word is packed as sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0. Bit 31 always equals the `in_sign` of the same item.
- R9: A result appears on `out_word` one clock after its input is presented with `in_valid` high, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is low, `out_word` holds its last value.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_word` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item is valid this cycle |
| in_enable | input | 1 | High to normalize, low to forward fields unchanged |
| in_sign | input | 1 | Sign of the raw result |
| in_exp | input | 8 | Biased exponent of the raw result |
| in_mant | input | 48 | Raw significand, binary point between bits 46 and 45 |
| out_valid | output | 1 | Registered result is valid |
| out_word | output | 32 | Packed result: sign, exponent, fraction |

## Verification
Every path in this stage is combinational up to one register, so a fault shows at the ports on the very next cycle after the offending input. A leading-one encoder that reports the wrong position shows up as a wrong exponent and a shifted fraction. That error is exposed by walking the leading one through every position and by boundary exponents equal to N and N+1. A wrong overflow or underflow threshold shows up as a finite value where infinity or zero is due, or the reverse. Exponents 253, 254 and 255 on the right-shift path target that threshold.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 23;
  localparam int MANT_W_DEF = 48;

  typedef enum logic [2:0] {
    PATH_BYPASS,
    PATH_KEEP,
    PATH_RIGHT,
    PATH_LEFT,
    PATH_ZERO,
    PATH_INF
  } norm_path_e;
endpackage

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int W  = 48,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [PW-1:0] pos
);
  // Scan upward; the last set bit seen is the most significant one.
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/mant_lshift.sv
module mant_lshift #(
  parameter int W  = 48,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = din;

  // One mux level per bit of the shift amount.
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP < W) begin : g_shift
      assign stage[k+1] = amt[k] ? {stage[k][W-1-STEP:0], {STEP{1'b0}}} : stage[k];
    end else begin : g_clear
      assign stage[k+1] = amt[k] ? '0 : stage[k];
    end
  end

  assign dout = stage[SW];
endmodule

// File: rtl/exp_adjust.sv
module exp_adjust #(
  parameter int EW = 8,
  parameter int SW = 6
) (
  input  logic [EW-1:0] exp_in,
  input  logic [SW-1:0] lshift,
  output logic [EW-1:0] exp_dec,
  output logic          underflow,
  output logic [EW-1:0] exp_inc,
  output logic          overflow
);
  localparam int CW = EW + SW;
  localparam logic [EW-1:0] SAT_LIMIT = {{(EW-1){1'b1}}, 1'b0};

  logic [CW-1:0] ext_exp;
  logic [CW-1:0] ext_shift;
  logic [CW-1:0] diff;

  assign ext_exp   = {{SW{1'b0}}, exp_in};
  assign ext_shift = {{EW{1'b0}}, lshift};
  assign diff      = ext_exp - ext_shift;

  assign exp_dec   = diff[EW-1:0];
  assign underflow = ext_shift >= ext_exp;
  assign exp_inc   = exp_in + {{(EW-1){1'b0}}, 1'b1};
  assign overflow  = exp_in >= SAT_LIMIT;
endmodule

// File: rtl/fp_normalizer.sv
module fp_normalizer
  import fpn_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int MANT_W = MANT_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_enable,
  input  logic                      in_sign,
  input  logic [EXP_W-1:0]          in_exp,
  input  logic [MANT_W-1:0]         in_mant,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     out_word
);
  localparam int WORD_W   = EXP_W + FRAC_W + 1;
  localparam int SW       = $clog2(MANT_W);
  localparam int HEAD_POS = MANT_W - 2;
  localparam logic [SW-1:0] HEAD_POS_V = SW'(HEAD_POS);

  logic              lead_found;
  logic [SW-1:0]     lead_pos;
  logic [SW-1:0]     lshift_amt;
  logic [MANT_W-1:0] left_mant;
  logic [EXP_W-1:0]  exp_dec;
  logic [EXP_W-1:0]  exp_inc;
  logic              underflow;
  logic              overflow;
  logic [1:0]        head;
  norm_path_e        path;
  logic [WORD_W-1:0] next_word;

  assign head = in_mant[MANT_W-1 -: 2];

  lead_one_enc #(.W(MANT_W), .PW(SW)) u_lead (
    .vec   (in_mant),
    .found (lead_found),
    .pos   (lead_pos)
  );

  assign lshift_amt = HEAD_POS_V - lead_pos;

  mant_lshift #(.W(MANT_W), .SW(SW)) u_shift (
    .din  (in_mant),
    .amt  (lshift_amt),
    .dout (left_mant)
  );

  exp_adjust #(.EW(EXP_W), .SW(SW)) u_exp (
    .exp_in    (in_exp),
    .lshift    (lshift_amt),
    .exp_dec   (exp_dec),
    .underflow (underflow),
    .exp_inc   (exp_inc),
    .overflow  (overflow)
  );

  // Path selection: ordering matters, zero mantissa wins over head decode.
  always_comb begin
    if (!in_enable)            path = PATH_BYPASS;
    else if (!lead_found)      path = PATH_ZERO;
    else if (head[1])          path = overflow ? PATH_INF : PATH_RIGHT;
    else if (head[0])          path = PATH_KEEP;
    else                       path = underflow ? PATH_ZERO : PATH_LEFT;
  end

  always_comb begin
    unique case (path)
      PATH_BYPASS,
      PATH_KEEP:  next_word = {in_sign, in_exp,  in_mant[MANT_W-3 -: FRAC_W]};
      PATH_RIGHT: next_word = {in_sign, exp_inc, in_mant[MANT_W-2 -: FRAC_W]};
      PATH_LEFT:  next_word = {in_sign, exp_dec, left_mant[MANT_W-3 -: FRAC_W]};
      PATH_INF:   next_word = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      default:    next_word = {in_sign, {(WORD_W-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= next_word;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_lag_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word)));
  assert_sign_kept_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[WORD_W-1] == $past(in_sign)));
  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_enable) |=>
      (out_word == $past({in_sign, in_exp, in_mant[MANT_W-3 -: FRAC_W]})));
  assert_lead_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (in_enable && head == 2'b00 && lead_found) |-> left_mant[HEAD_POS]);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_enable && in_mant[MANT_W-1] && overflow) |=>
      (out_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  assert_zero_mant_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_enable && !(|in_mant)) |=> (out_word[WORD_W-2:0] == '0));
endmodule

// File: tb/fp_normalizer_test.sv
module fp_normalizer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_enable = 1'b0;
  logic        in_sign = 1'b0;
  logic [7:0]  in_exp = '0;
  logic [47:0] in_mant = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  fp_normalizer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_enable(in_enable),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [31:0] model(logic en, logic s, logic [7:0] e, logic [47:0] m);
    int p;
    int n;
    logic [47:0] sh;
    if (!en) return {s, e, m[45:23]};
    if (m == 0) return {s, 31'h0};
    if (m[47]) begin
      if (e >= 8'd254) return {s, 8'hFF, 23'h0};
      return {s, e + 8'd1, m[46:24]};
    end
    if (m[46]) return {s, e, m[45:23]};
    p = 0;
    for (int i = 0; i < 48; i++) if (m[i]) p = i;
    n = 46 - p;
    if (n >= int'(e)) return {s, 31'h0};
    sh = m << n;
    return {s, 8'(int'(e) - n), sh[45:23]};
  endfunction

  function automatic string tag_of(logic en, logic [7:0] e, logic [47:0] m);
    int p;
    if (!en) return "R1";
    if (m == 0) return "R7";
    if (m[47]) return (e >= 8'd254) ? "R5" : "R3";
    if (m[46]) return "R2";
    p = 0;
    for (int i = 0; i < 48; i++) if (m[i]) p = i;
    return ((46 - p) >= int'(e)) ? "R6" : "R4";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(logic en, logic s, logic [7:0] e, logic [47:0] m);
    in_valid  = 1'b1;
    in_enable = en;
    in_sign   = s;
    in_exp    = e;
    in_mant   = m;
    exp_q.push_back(model(en, s, e, m));
    tag_q.push_back(tag_of(en, e, m));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard (R8 packing checked with every comparison)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 actual=unexpected_valid expected=no_valid");
      end else begin
        check({tag_q.pop_front(), "/R8"}, out_word, exp_q.pop_front());
        last_word = out_word;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {31'h0, out_valid}, 32'h0);
    check("R10", out_word, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 bypass with all heads
    drive(1'b0, 1'b1, 8'h80, 48'hC000_0000_0001);
    drive(1'b0, 1'b0, 8'h05, 48'h0000_0000_1234);
    // R2 already normalized
    drive(1'b1, 1'b0, 8'h7F, 48'h5555_AAAA_FFFF);
    drive(1'b1, 1'b1, 8'h00, 48'h4000_0000_0000);
    // R3 right shift
    drive(1'b1, 1'b0, 8'h7F, 48'h8000_0080_0000);
    drive(1'b1, 1'b1, 8'd253, 48'hFFFF_FFFF_FFFF);
    // R5 saturation
    drive(1'b1, 1'b0, 8'd254, 48'h8000_0000_0000);
    drive(1'b1, 1'b1, 8'd255, 48'hC123_4567_89AB);
    // R7 zero mantissa
    drive(1'b1, 1'b1, 8'h90, 48'h0);
    // R4 / R6 boundaries: leading one at bit 0, N=46
    drive(1'b1, 1'b0, 8'd47, 48'h1);
    drive(1'b1, 1'b1, 8'd46, 48'h1);
    drive(1'b1, 1'b0, 8'd3,  48'h2000_0000_0000);
    drive(1'b1, 1'b0, 8'd1,  48'h2000_0000_0000);
    // R4 truncation: low bits dropped after shift
    drive(1'b1, 1'b0, 8'h80, 48'h0000_00FF_FFFF);
    // walk the leading one through every position below the head
    for (int p = 0; p < 46; p++) begin
      drive(1'b1, p[0], 8'd100, (48'h1 << p) | 48'(p));
    end
    idle(3);

    // R9 hold while idle
    check("R9", {31'h0, out_valid}, 32'h0);
    check("R9", out_word, last_word);
    idle(2);
    check("R9", out_word, last_word);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [47:0] m;
      m = {$urandom, $urandom} >> ($urandom % 49);
      drive(($urandom % 8) != 0, $urandom % 2, 8'($urandom), m);
    end
    idle(3);

    // R10 mid-run reset
    drive(1'b1, 1'b1, 8'h70, 48'h4000_0000_0001);
    idle(2);
    rst = 1'b1;
    @(negedge clk);
    check("R10", {31'h0, out_valid}, 32'h0);
    check("R10", out_word, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", out_word, 32'h0);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R9 actual=%0d leftover expected=0", exp_q.size());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule